// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers one-cycle event pulses from up to twelve sources into a sticky status word and drives one level-sensitive interrupt line. The line is high while at least one status bit is set and not masked. Eight general-purpose sources feed status bits 7:0. Three strobes from a real-time clock feed bits 8 to 10: the periodic tick, the alarm match and the rejected-update error. A push-button level input is synchronised, and only its rising edge sets bit 11. Bits 15:12 have no source.

Software uses a byte-wide register port. A write takes one cycle with `reg_wr` high. A read is combinational: `reg_rdata` follows `reg_addr` in the same cycle. The 16-bit mask and the status word are each read as a low byte and a high byte. Status bits are cleared through two write-only acknowledge bytes, where a written one clears the bit. Every port is a plain control or status pin. The block has no streaming data path, so it needs no valid/ready handshake and has no back-pressure.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the mask reads 0x0FFF (low byte 0xFF at address 0, high byte 0x0F at address 1), the status reads zero (addresses 2 and 3), and `irq` is low.
- R2: `irq` is high exactly when some bit of (status AND NOT mask) is set. It follows each mask write, acknowledge write or new event from the cycle after that register update.
- R3: A write to address 0 replaces mask bits 7:0 and leaves mask bits 15:8 unchanged.
- R4: A write to address 1 replaces mask bits 15:8 and leaves mask bits 7:0 unchanged.
- R5: A write to address 4 clears each status bit in 7:0 whose written bit is 1, and leaves every other status bit as it was.
- R6: A write to address 5 clears each status bit in 15:8 whose written bit is 1, and leaves every other status bit as it was.
- R7: Addresses 4 and 5 read as zero, and so do the unused addresses 6 and 7.
- R8: A low-to-high change on `btn_level` sets status bit 11 three clock edges later. A level held high does not set the bit again after an acknowledge.
- R9: `ev_strobe[i]` sets status bit i for i in 0 to 7. `rtc_tick` sets bit 8, `rtc_alarm` sets bit 9 and `rtc_upd_err` sets bit 10.
- R10: When an event and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R11: Events are recorded while masked. Unmasking a pending bit raises `irq` in the cycle after the mask write.
- R12: Status bits 15:12 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_strobe | input | 8 | General event pulses, status bits 7:0 |
| rtc_tick | input | 1 | RTC periodic tick pulse, status bit 8 |
| rtc_alarm | input | 1 | RTC alarm match pulse, status bit 9 |
| rtc_upd_err | input | 1 | RTC rejected-update pulse, status bit 10 |
| btn_level | input | 1 | Asynchronous push-button level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte for `reg_addr` |
| irq | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default parameters: a 16-bit status word split into two byte lanes and a two-stage button synchroniser. These defaults make the full byte split reachable. They cover high-byte writes that must leave the low lane alone, and acknowledges that reach the RTC and button bits. With two synchroniser stages the button edge is due on a known third clock edge. The bench can therefore watch a held level and confirm that it never sets the bit again.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int BYTE_W = 8;
  localparam int STAT_W = 16;
  localparam int ADDR_W = 3;
  localparam int GEN_W  = 8;

  localparam logic [ADDR_W-1:0] A_MASK_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACK_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACK_HI  = 3'd5;

  localparam int BIT_TICK  = 8;
  localparam int BIT_ALARM = 9;
  localparam int BIT_UPERR = 10;
  localparam int BIT_BTN   = 11;

  localparam logic [STAT_W-1:0] MASK_RST = 16'h0FFF;
endpackage

// File: rtl/irqagg_btn_edge.sv
module irqagg_btn_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= level_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R8
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/irqagg_mask_reg.sv
module irqagg_mask_reg
  import irqagg_pkg::*;
#(
  parameter int                W     = STAT_W,
  parameter logic [STAT_W-1:0] RST_V = MASK_RST
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [W/BYTE_W-1:0]       lane_we,
  input  logic [BYTE_W-1:0]         wdata,
  output logic [W-1:0]              mask
);
  localparam int LANES = W / BYTE_W;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask[l*BYTE_W +: BYTE_W] <= RST_V[l*BYTE_W +: BYTE_W];
        else if (lane_we[l]) mask[l*BYTE_W +: BYTE_W] <= wdata;
      end

      // R3 R4
      lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_we[l] |=> (mask[l*BYTE_W +: BYTE_W] == $past(mask[l*BYTE_W +: BYTE_W])));
    end
  endgenerate
endmodule

// File: rtl/irqagg_status_reg.sv
module irqagg_status_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else status <= (status & ~clr_vec) | set_vec;
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R5 R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(status & ~clr_vec)) == '0));
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irqagg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GEN_W-1:0]  ev_strobe,
  input  logic              rtc_tick,
  input  logic              rtc_alarm,
  input  logic              rtc_upd_err,
  input  logic              btn_level,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int LANES = STAT_W / BYTE_W;

  logic              btn_rise;
  logic [STAT_W-1:0] set_vec, clr_vec, status, mask;
  logic [LANES-1:0]  mask_we, ack_we;

  irqagg_btn_edge #(.SYNC_STAGES(SYNC_STAGES)) u_btn (
    .clk(clk), .rst_n(rst_n), .level_in(btn_level), .rise(btn_rise)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[GEN_W-1:0] = ev_strobe;
    set_vec[BIT_TICK]  = rtc_tick;
    set_vec[BIT_ALARM] = rtc_alarm;
    set_vec[BIT_UPERR] = rtc_upd_err;
    set_vec[BIT_BTN]   = btn_rise;
  end

  assign mask_we[0] = reg_wr && (reg_addr == A_MASK_LO);
  assign mask_we[1] = reg_wr && (reg_addr == A_MASK_HI);
  assign ack_we[0]  = reg_wr && (reg_addr == A_ACK_LO);
  assign ack_we[1]  = reg_wr && (reg_addr == A_ACK_HI);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_clr
      assign clr_vec[l*BYTE_W +: BYTE_W] = ack_we[l] ? reg_wdata : '0;
    end
  endgenerate

  irqagg_mask_reg #(.W(STAT_W), .RST_V(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .lane_we(mask_we), .wdata(reg_wdata), .mask(mask)
  );

  irqagg_status_reg #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .status(status)
  );

  always_comb begin
    unique case (reg_addr)
      A_MASK_LO: reg_rdata = mask[BYTE_W-1:0];
      A_MASK_HI: reg_rdata = mask[STAT_W-1:BYTE_W];
      A_STAT_LO: reg_rdata = status[BYTE_W-1:0];
      A_STAT_HI: reg_rdata = status[STAT_W-1:BYTE_W];
      default:   reg_rdata = '0;
    endcase
  end

  assign irq = |(status & ~mask);

  // R12
  upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_STAT_HI) |-> (reg_rdata[BYTE_W-1:4] == '0));

  // R7
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= A_ACK_LO) |-> (reg_rdata == '0));
endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] ev_strobe = 0;
  logic       rtc_tick = 0, rtc_alarm = 0, rtc_upd_err = 0, btn_level = 0;
  logic       reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit is_irq; logic [2:0] addr; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  irq_status_agg u_irq_status_agg (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .rtc_tick(rtc_tick),
    .rtc_alarm(rtc_alarm), .rtc_upd_err(rtc_upd_err), .btn_level(btn_level),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: pops expectations at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      act = it.is_irq ? {7'd0, irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: addr %0d actual %h expected %h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    step();
    reg_addr = a;
    it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    step();
    it.is_irq = 1; it.addr = reg_addr; it.exp = {7'd0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step();
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic pulse(input logic [7:0] g, input logic t, input logic al, input logic ue);
    step();
    ev_strobe = g; rtc_tick = t; rtc_alarm = al; rtc_upd_err = ue;
    step();
    ev_strobe = 0; rtc_tick = 0; rtc_alarm = 0; rtc_upd_err = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    exp_rd(3'd0, 8'hFF, "R1 mask lo");
    exp_rd(3'd1, 8'h0F, "R1 mask hi");
    exp_rd(3'd2, 8'h00, "R1 status lo");
    exp_rd(3'd3, 8'h00, "R1 status hi");
    exp_irq(0, "R1 irq");

    pulse(8'h05, 0, 0, 0);
    exp_rd(3'd2, 8'h05, "R11 masked recorded");
    exp_irq(0, "R2 masked no irq");
    wr(3'd0, 8'hFA);
    exp_irq(1, "R11 unmask raises");
    exp_rd(3'd1, 8'h0F, "R3 hi kept");
    exp_rd(3'd0, 8'hFA, "R3 lo written");

    wr(3'd4, 8'h01);
    exp_rd(3'd2, 8'h04, "R5 partial ack");
    exp_irq(1, "R2 still pending");
    exp_rd(3'd4, 8'h00, "R7 ack lo reads 0");
    exp_rd(3'd5, 8'h00, "R7 ack hi reads 0");
    exp_rd(3'd6, 8'h00, "R7 addr 6");
    exp_rd(3'd7, 8'h00, "R7 addr 7");
    wr(3'd4, 8'h04);
    exp_rd(3'd2, 8'h00, "R5 full ack");
    exp_irq(0, "R2 cleared");

    pulse(0, 1, 0, 0);
    exp_rd(3'd3, 8'h01, "R9 tick bit8");
    pulse(0, 0, 1, 0);
    exp_rd(3'd3, 8'h03, "R9 alarm bit9");
    pulse(0, 0, 0, 1);
    exp_rd(3'd3, 8'h07, "R9 upd err bit10");
    exp_irq(0, "R2 hi masked");
    wr(3'd1, 8'h0B);
    exp_irq(1, "R11 unmask bit10");
    exp_rd(3'd0, 8'hFA, "R4 lo kept");
    wr(3'd5, 8'h04);
    exp_rd(3'd3, 8'h03, "R6 ack bit10");
    exp_irq(0, "R2 after ack hi");
    wr(3'd5, 8'h03);
    exp_rd(3'd3, 8'h00, "R6 ack rest");

    step(); btn_level = 1;
    repeat (4) step();
    exp_rd(3'd3, 8'h08, "R8 button rise");
    wr(3'd5, 8'h08);
    repeat (6) step();
    exp_rd(3'd3, 8'h00, "R8 held no reset");
    btn_level = 0;
    repeat (4) step();
    btn_level = 1;
    repeat (4) step();
    exp_rd(3'd3, 8'h08, "R8 second rise");
    wr(3'd5, 8'h08);

    step();
    ev_strobe = 8'h02; reg_wr = 1; reg_addr = 3'd4; reg_wdata = 8'h02;
    step();
    ev_strobe = 0; reg_wr = 0;
    exp_rd(3'd2, 8'h02, "R10 event wins");

    pulse(8'hFF, 1, 1, 1);
    exp_rd(3'd3, 8'h07, "R12 upper nibble zero");
    exp_rd(3'd2, 8'hFF, "R9 all general");

    repeat (3) step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule